// File: doc/BRIEF.md
# Write-Through Valid/Invalid Coherency Tracker

This block keeps the tags and a single valid bit per line for a direct-mapped, write-through cache that shares a snooping bus with other agents. A processor-side port offers read and write requests. For each accepted request the block reports hit or miss in the same cycle. It then either serves the request locally or issues one bus command: a line fill for a read miss, or a single write for every write.

While a bus command is outstanding, the processor port stalls until the bus acknowledges. A read miss marks its line valid when the fill is acknowledged. Writes never allocate a line. Another agent's write arrives on the snoop port as a line address. It invalidates the local line when that line is valid and holds the same tag.

The block holds no data, no write buffer and no arbitration logic. Its outputs are the hit flag, the ready flag and the bus command strobes with their address.

Top module: `wtvTracker`

## Requirements
- R1: A synchronous reset clears every valid bit and returns the block to idle. In the first cycle after reset, `cpuReqReady` is high, and a read of any address reports `cpuHit` low.
- R2: Suppose a read is accepted while its line is valid and holds the same tag. Then `cpuHit` is high in the acceptance cycle. In the next cycle neither bus strobe is high and `cpuReqReady` stays high.
- R3: A read accepted with `cpuHit` low raises `busFillStrobe` for exactly one cycle, in the cycle after acceptance. While that strobe is high, `busCmdAddr` carries the line address: the request address with its low `OFFSET_W` bits zero.
- R4: A fill completes when `busAck` is high in any cycle of the fill wait. Its line then becomes valid with the request's tag. A later read of any address in that line hits.
- R5: Every accepted write, hit or miss, raises `busWriteStrobe` for exactly one cycle, in the cycle after acceptance. `busCmdAddr` then carries the full write address. `busFillStrobe` and `busWriteStrobe` are never high together.
- R6: A write miss allocates no line, so a following read of that address misses. A write hit leaves its line valid.
- R7: From the cycle after a bus command is issued until `busAck` is sampled, `cpuReqReady` is low and requests are ignored. In the next cycle `cpuReqReady` is high again. `busAck` has no effect while the block is idle.
- R8: When `snoopValid` is high and the line selected by `snoopLine` is valid with the same tag, that line is invalid from the next cycle on. A snoop with a different tag leaves the line as it was.
- R9: A fill may complete in the same cycle as a snoop to the same index. In that case the fill is dropped: the line keeps its earlier state, subject only to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Processor byte address |
| cpuReqReady | output | 1 | Block can accept a request this cycle |
| cpuHit | output | 1 | Accepted request hits a valid line |
| busFillStrobe | output | 1 | One-cycle line-fill command |
| busWriteStrobe | output | 1 | One-cycle single-write command |
| busCmdAddr | output | ADDR_W | Address of the current bus command |
| busAck | input | 1 | Bus completion of the outstanding command |
| snoopValid | input | 1 | Another agent's write is observed |
| snoopLine | input | ADDR_W-OFFSET_W | Line address of the snooped write |

## Verification
The assertions assume that `busAck` and snoops can arrive in any cycle. They also assume that requests may be held or dropped while `cpuReqReady` is low, and that the address seen in the acceptance cycle is the one that counts. The stimulus therefore drives every input freely on each cycle. It includes acknowledgements in the strobe cycle itself, acknowledgements while idle, and requests presented during a stall. Addresses are drawn from a few tags over a few indices, so that hits, conflicting tags, snoop matches and fill/snoop collisions all occur often.

// File: rtl/wtvPkg.sv
`timescale 1ns/1ps
package wtvPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE} ctrlState_t;

  typedef struct packed {
    logic captureReq;   // latch request address for a bus command
    logic commitFill;   // fill acknowledged: write tag, set valid
  } ctrlStrobe_t;
endpackage

// File: rtl/wtvTagStore.sv
`timescale 1ns/1ps
module wtvTagStore
  import wtvPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INDEX_W  = 4,
  parameter int OFFSET_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  ctrlStrobe_t              strobe,
  input  logic                     snoopValid,
  input  logic [ADDR_W-OFFSET_W-1:0] snoopLine,
  output logic                     lookupHit,
  output logic [ADDR_W-1:0]        cmdAddr
);
  localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] validBits;
  logic [TAG_W-1:0] tagMem [LINES];

  logic [ADDR_W-1:0]  pendAddr;
  logic               pendWrite;

  logic [INDEX_W-1:0] reqIdx, pendIdx, snoopIdx;
  logic [TAG_W-1:0]   reqTag, pendTag, snoopTag;
  logic               snoopKill, fillBlocked;

  assign reqIdx   = reqAddr[OFFSET_W +: INDEX_W];
  assign reqTag   = reqAddr[ADDR_W-1 -: TAG_W];
  assign pendIdx  = pendAddr[OFFSET_W +: INDEX_W];
  assign pendTag  = pendAddr[ADDR_W-1 -: TAG_W];
  assign snoopIdx = snoopLine[INDEX_W-1:0];
  assign snoopTag = snoopLine[ADDR_W-OFFSET_W-1 -: TAG_W];

  assign lookupHit   = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign snoopKill   = snoopValid && validBits[snoopIdx] && (tagMem[snoopIdx] == snoopTag);
  assign fillBlocked = snoopValid && (snoopIdx == pendIdx);

  assign cmdAddr = pendWrite ? pendAddr
                             : {pendAddr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pendAddr  <= '0;
      pendWrite <= 1'b0;
    end else if (strobe.captureReq) begin
      pendAddr  <= reqAddr;
      pendWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
    end else begin
      if (strobe.commitFill && !fillBlocked) validBits[pendIdx] <= 1'b1;
      if (snoopKill)                         validBits[snoopIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitFill && !fillBlocked) tagMem[pendIdx] <= pendTag;
  end
endmodule

// File: rtl/wtvControl.sv
`timescale 1ns/1ps
module wtvControl
  import wtvPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuReqValid,
  input  logic        cpuReqWrite,
  input  logic        lookupHit,
  input  logic        busAck,
  output logic        cpuReqReady,
  output ctrlStrobe_t strobe,
  output logic        busFillStrobe,
  output logic        busWriteStrobe
);
  ctrlState_t state, stateNext;
  logic accept, needFill, needWrite;

  assign cpuReqReady = (state == ST_IDLE);
  assign accept      = cpuReqValid && cpuReqReady;
  assign needFill    = accept && !cpuReqWrite && !lookupHit;
  assign needWrite   = accept && cpuReqWrite;

  assign strobe.captureReq = needFill || needWrite;
  assign strobe.commitFill = (state == ST_FILL) && busAck;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (needWrite)     stateNext = ST_WRITE;
        else if (needFill) stateNext = ST_FILL;
      end
      ST_FILL, ST_WRITE: if (busAck) stateNext = ST_IDLE;
      default:           stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      busFillStrobe  <= 1'b0;
      busWriteStrobe <= 1'b0;
    end else begin
      state          <= stateNext;
      busFillStrobe  <= needFill;
      busWriteStrobe <= needWrite;
    end
  end
endmodule

// File: rtl/wtvTracker.sv
`timescale 1ns/1ps
module wtvTracker
  import wtvPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INDEX_W  = 4,
  parameter int OFFSET_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpuReqValid,
  input  logic                       cpuReqWrite,
  input  logic [ADDR_W-1:0]          cpuReqAddr,
  output logic                       cpuReqReady,
  output logic                       cpuHit,
  output logic                       busFillStrobe,
  output logic                       busWriteStrobe,
  output logic [ADDR_W-1:0]          busCmdAddr,
  input  logic                       busAck,
  input  logic                       snoopValid,
  input  logic [ADDR_W-OFFSET_W-1:0] snoopLine
);
  ctrlStrobe_t strobe;
  logic        lookupHit;

  wtvControl uCtrl (
    .clk(clk), .rst(rst),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
    .lookupHit(lookupHit), .busAck(busAck),
    .cpuReqReady(cpuReqReady), .strobe(strobe),
    .busFillStrobe(busFillStrobe), .busWriteStrobe(busWriteStrobe)
  );

  wtvTagStore #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W)) uStore (
    .clk(clk), .rst(rst),
    .reqAddr(cpuReqAddr), .reqWrite(cpuReqWrite), .strobe(strobe),
    .snoopValid(snoopValid), .snoopLine(snoopLine),
    .lookupHit(lookupHit), .cmdAddr(busCmdAddr)
  );

  assign cpuHit = cpuReqValid && cpuReqReady && lookupHit;
endmodule

// File: rtl/wtvChecker.sv
`timescale 1ns/1ps
module wtvChecker #(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReqValid,
  input logic              cpuReqWrite,
  input logic [ADDR_W-1:0] cpuReqAddr,
  input logic              cpuReqReady,
  input logic              cpuHit,
  input logic              busFillStrobe,
  input logic              busWriteStrobe,
  input logic [ADDR_W-1:0] busCmdAddr
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> cpuReqReady); // R1

  AST_HIT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    cpuHit |-> cpuReqReady); // R2

  AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpuReqValid && cpuReqReady && !cpuReqWrite && cpuHit)
    |=> (!busFillStrobe && !busWriteStrobe && cpuReqReady)); // R2

  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (rst)
    (cpuReqValid && cpuReqReady && !cpuReqWrite && !cpuHit)
    |=> (busFillStrobe && busCmdAddr[ADDR_W-1:OFFSET_W] == $past(cpuReqAddr[ADDR_W-1:OFFSET_W])
         && busCmdAddr[OFFSET_W-1:0] == '0)); // R3

  AST_FILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    busFillStrobe |=> !busFillStrobe); // R3

  AST_WRITE_TO_BUS: assert property (@(posedge clk) disable iff (rst)
    (cpuReqValid && cpuReqReady && cpuReqWrite)
    |=> (busWriteStrobe && busCmdAddr == $past(cpuReqAddr))); // R5

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(busFillStrobe && busWriteStrobe)); // R5

  AST_STALL_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    (busFillStrobe || busWriteStrobe) |-> !cpuReqReady); // R7
endmodule

bind wtvTracker wtvChecker #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) uChk (
  .clk(clk), .rst(rst), .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
  .cpuReqAddr(cpuReqAddr), .cpuReqReady(cpuReqReady), .cpuHit(cpuHit),
  .busFillStrobe(busFillStrobe), .busWriteStrobe(busWriteStrobe),
  .busCmdAddr(busCmdAddr)
);

// File: tb/wtvTracker_bench.sv
`timescale 1ns/1ps
module wtvTracker_bench;
  localparam int AW = 16, IW = 4, OW = 2, TW = AW - IW - OW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0, busAck = 1'b0, snoopValid = 1'b0;
  logic [AW-1:0] cpuReqAddr = '0;
  logic [AW-OW-1:0] snoopLine = '0;
  logic cpuReqReady, cpuHit, busFillStrobe, busWriteStrobe;
  logic [AW-1:0] busCmdAddr;

  int checks = 0, failures = 0, cycles = 0;
  bit started = 0;

  always #10 clk = ~clk;

  wtvTracker #(.ADDR_W(AW), .INDEX_W(IW), .OFFSET_W(OW)) u_wtvTracker (
    .clk(clk), .rst(rst), .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqReady(cpuReqReady), .cpuHit(cpuHit),
    .busFillStrobe(busFillStrobe), .busWriteStrobe(busWriteStrobe),
    .busCmdAddr(busCmdAddr), .busAck(busAck), .snoopValid(snoopValid),
    .snoopLine(snoopLine)
  );

  // behavioural reference model
  bit mValid [1<<IW];
  int mTag   [1<<IW];
  int mState = 0;            // 0 idle, 1 waiting fill, 2 waiting write
  bit mFillStb = 0, mWrStb = 0;
  int mPendAddr = 0;
  bit mPendWrite = 0;

  function automatic int idxOf(int a);  return (a >> OW) & ((1<<IW)-1); endfunction
  function automatic int tagOf(int a);  return (a >> (OW+IW)) & ((1<<TW)-1); endfunction
  function automatic bit modelHit(int a);
    return mValid[idxOf(a)] && mTag[idxOf(a)] == tagOf(a);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mValid[i]) mValid[i] = 0;
      mState = 0; mFillStb = 0; mWrStb = 0;
    end else begin
      int sIdx, sTag, a;
      bit acc, hit, kill, commit;
      a    = int'(cpuReqAddr);
      sIdx = int'(snoopLine) & ((1<<IW)-1);
      sTag = int'(snoopLine) >> IW;
      acc  = cpuReqValid && mState == 0;
      hit  = acc && modelHit(a);
      kill = snoopValid && mValid[sIdx] && mTag[sIdx] == sTag;
      commit = (mState == 1) && busAck && !(snoopValid && sIdx == idxOf(mPendAddr));
      mFillStb = acc && !cpuReqWrite && !hit;
      mWrStb   = acc && cpuReqWrite;
      if (commit) begin
        mValid[idxOf(mPendAddr)] = 1;
        mTag[idxOf(mPendAddr)]   = tagOf(mPendAddr);
      end
      if (kill) mValid[sIdx] = 0;
      if (acc && (cpuReqWrite || !hit)) begin
        mPendAddr = a; mPendWrite = cpuReqWrite; mState = cpuReqWrite ? 2 : 1;
      end else if (mState != 0 && busAck) begin
        mState = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (started && !rst) begin
      int expAddr;
      chk("R7", int'(cpuReqReady), int'(mState == 0), "ready");
      chk("R2", int'(cpuHit), int'(cpuReqValid && mState == 0 && modelHit(int'(cpuReqAddr))), "hit");
      chk("R3", int'(busFillStrobe), int'(mFillStb), "fill strobe");
      chk("R5", int'(busWriteStrobe), int'(mWrStb), "write strobe");
      expAddr = mPendWrite ? mPendAddr : (mPendAddr & ~((1<<OW)-1));
      if (mFillStb || mWrStb) chk("R5", int'(busCmdAddr), expAddr, "command address");
    end
  end

  task automatic step(input bit v, input bit w, input int a, input bit ack,
                      input bit sv, input int sl);
    @(negedge clk);
    cpuReqValid = v; cpuReqWrite = w; cpuReqAddr = AW'(a);
    busAck = ack; snoopValid = sv; snoopLine = (AW-OW)'(sl);
  endtask

  function automatic int mk(int tag, int idx, int off);
    return (tag << (OW+IW)) | (idx << OW) | off;
  endfunction

  initial begin : watchdog
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int aA, aB, aC;
    aA = mk(5, 3, 1); aB = mk(6, 4, 2); aC = mk(9, 7, 3);
    repeat (3) @(negedge clk);
    step(0, 0, 0, 1, 0, 0);          // reset released at this negedge
    rst = 0; started = 1;
    // R1: reset cleared lines
    step(1, 0, aA, 0, 0, 0); #3;
    chk("R1", int'(cpuReqReady), 1, "ready after reset");
    chk("R1", int'(cpuHit), 0, "read after reset");
    step(0, 0, 0, 1, 0, 0);          // ack in the strobe cycle
    // R4: filled line now hits
    step(1, 0, aA ^ 2, 0, 0, 0); #3;
    chk("R4", int'(cpuHit), 1, "hit after fill");
    // R6: write hit keeps line valid
    step(1, 1, aA, 0, 0, 0); #3;
    chk("R6", int'(cpuHit), 1, "write hit");
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, aA, 1, 0, 0);         // request during stall ignored (R7)
    step(1, 0, aA, 0, 0, 0); #3;
    chk("R6", int'(cpuHit), 1, "line valid after write hit");
    // R6: write miss no allocate
    step(1, 1, aB, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(1, 0, aB, 0, 0, 0); #3;
    chk("R6", int'(cpuHit), 0, "no allocate on write miss");
    step(0, 0, 0, 1, 0, 0);
    // R8: matching snoop invalidates, other tag does not
    step(0, 0, 0, 0, 1, mk(7, 4, 0) >> OW);
    step(0, 0, 0, 0, 1, aA >> OW);
    step(1, 0, aB, 0, 0, 0); #3;
    chk("R8", int'(cpuHit), 1, "other-tag snoop keeps line");
    step(1, 0, aA, 0, 0, 0); #3;
    chk("R8", int'(cpuHit), 0, "matching snoop invalidates");
    step(0, 0, 0, 1, 0, 0);
    // R9: fill colliding with same-index snoop is dropped
    step(1, 0, aC, 0, 0, 0);
    step(0, 0, 0, 1, 1, mk(2, 7, 0) >> OW);
    step(1, 0, aC, 0, 0, 0); #3;
    chk("R9", int'(cpuHit), 0, "fill dropped on collision");
    step(0, 0, 0, 1, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int tg, ix, sx, st;
      tg = (n % 3 == 0) ? 5 : ((n % 3 == 1) ? 6 : 9);
      tg = ($urandom % 4 == 0) ? int'($urandom % 3) + 5 : tg;
      ix = int'($urandom % 4);
      sx = int'($urandom % 4);
      st = ($urandom % 2 == 0) ? 5 : 6;
      step($urandom % 2 == 0, $urandom % 3 == 0, mk(tg, ix, int'($urandom % 4)),
           $urandom % 3 == 0, $urandom % 5 == 0, mk(st, sx, 0) >> OW);
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk); #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule